// File: doc/BRIEF.md
# OFDM Cyclic Prefix Extender

This block sits after the inverse transform in an OFDM transmit path. It receives time-domain symbols of 64 complex samples, each sample a 16-bit in-phase and a 16-bit quadrature value. For each symbol it produces 80 samples: a guard interval made by repeating the last 16 samples, followed by the whole symbol from its first sample. Both sides are valid/ready sample streams. The input has a start-of-symbol marker. The output marks the final sample of every extended symbol.

Storage is two symbol buffers that swap roles. One buffer fills from the input while the other drains to the output. Each buffer has a full flag, set when its 64th sample is written and cleared when its 80th output sample is taken. The write controller has two states. W_FILL accepts samples into the current write buffer. W_HOLD holds the input off because that buffer still contains a symbol that has not been sent. It moves W_FILL→W_HOLD when it completes a symbol while the other buffer is occupied, and W_HOLD→W_FILL when its buffer is freed.

The read controller has three states. R_IDLE waits for the current read buffer to fill. R_PREFIX reads addresses 48 to 63. R_BODY reads addresses 0 to 63. Its transitions are R_IDLE→R_PREFIX when the buffer is full, R_PREFIX→R_BODY after address 63 is taken, and R_BODY→R_PREFIX or R_BODY→R_IDLE after the final sample, depending on whether the other buffer is already full.

Top module: `cpx_extender`

## Requirements
- R1: Every output symbol is exactly 80 accepted samples long, and `out_last` is high on the 80th sample only.
- R2: Output samples 1 to 16 of a symbol are input samples 48 to 63 of that symbol, in ascending order.
- R3: Output samples 17 to 80 are input samples 0 to 63 of that symbol, in ascending order.
- R4: Sample values are not altered. The in-phase value appears on `out_i` and the quadrature value appears on `out_q`, bit for bit.
- R5: A second complete symbol is accepted without any input stall while the first symbol waits at the output. No more than two unsent symbols are ever held.
- R6: When two unsent symbols are held, `in_ready` is low, and it stays low until the final sample of the older symbol is taken.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i`, `out_q` and `out_last` stay unchanged into the next cycle.
- R8: An accepted sample with `in_first` high is stored as sample 0 of the symbol being filled, and any partial symbol collected before it is discarded.
- R9: When the output side is idle, `out_valid` rises on the second rising clock edge after the 64th sample of a symbol is accepted, and shows input sample 48.
- R10: If the next symbol is already complete when the 80th sample of a symbol is taken, its first prefix sample is valid in the very next cycle.
- R11: During and directly after reset, `out_valid` and `out_last` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample |
| in_first | input | 1 | Input sample is sample 0 of a symbol |
| in_i | input | 16 | In-phase input value |
| in_q | input | 16 | Quadrature input value |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Sink takes the output sample |
| out_last | output | 1 | Output sample is the 80th of its symbol |
| out_i | output | 16 | In-phase output value |
| out_q | output | 16 | Quadrature output value |

## Verification
The checker's symbol count assumes that the producer keeps `in_first`, `in_i` and `in_q` meaningful whenever `in_valid` is high. It also assumes that `in_first` is used only to start a symbol, so that the checker can count completed input symbols the same way the block does. The stimulus always drives `in_first` on sample 0, and on no other sample except in the one directed case that abandons a partial symbol. Inputs change only at the falling edge, and the sink's ready pattern is a fixed function of the cycle count. This keeps every transfer inside the valid/ready rules that the stall and capacity properties rely on.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    // Write-side controller states
    typedef enum logic [0:0] {
        W_FILL = 1'b0,
        W_HOLD = 1'b1
    } wr_state_t;

    // Read-side controller states
    typedef enum logic [1:0] {
        R_IDLE   = 2'd0,
        R_PREFIX = 2'd1,
        R_BODY   = 2'd2
    } rd_state_t;

endpackage

// File: rtl/cpx_bank.sv
module cpx_bank #(
    parameter int SMP_W   = 32,
    parameter int SYM_LEN = 64,
    localparam int IDX_W  = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [SMP_W-1:0] wr_data,
    input  logic             rd_sel,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [SMP_W-1:0] rd_data
);

    logic [SMP_W-1:0] rd_word [2];

    // One storage array per buffer; only the filling buffer is written
    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [SMP_W-1:0] mem [SYM_LEN];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_word[b] = mem[rd_addr];
    end

    assign rd_data = rd_word[rd_sel];

endmodule

// File: rtl/cpx_occupancy.sv
module cpx_occupancy (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_vec,
    input  logic [1:0] clr_vec,
    output logic [1:0] full
);

    // A buffer becomes full when its last input sample is written and
    // empty again when its last output sample is taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 2'b00;
        end else begin
            full <= (full | set_vec) & ~clr_vec;
        end
    end

endmodule

// File: rtl/cpx_wr_fsm.sv
module cpx_wr_fsm
    import cpx_pkg::*;
#(
    parameter int SYM_LEN = 64,
    localparam int IDX_W  = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [1:0]       full,
    input  logic [1:0]       clr_vec,
    output logic             in_ready,
    output logic             wr_en,
    output logic             wr_sel,
    output logic [IDX_W-1:0] wr_addr,
    output logic [1:0]       set_vec
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_LEN - 1);

    wr_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             sel_q, sel_d;
    logic             end_sym;
    logic             other_busy;
    logic             own_free;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_FILL;
            idx_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        in_ready = (state_q == W_FILL);
        wr_en    = in_valid && in_ready;
        wr_sel   = sel_q;
        wr_addr  = in_first ? '0 : idx_q;
        end_sym  = wr_en && (wr_addr == LAST_IDX);
        set_vec  = 2'b00;
        if (end_sym) begin
            set_vec[sel_q] = 1'b1;
        end
    end

    // Next state
    always_comb begin
        other_busy = full[~sel_q] && !clr_vec[~sel_q];
        own_free   = !full[sel_q] || clr_vec[sel_q];
        state_d    = state_q;
        idx_d      = idx_q;
        sel_d      = sel_q;
        unique case (state_q)
            W_FILL: begin
                if (end_sym) begin
                    idx_d   = '0;
                    sel_d   = ~sel_q;
                    state_d = other_busy ? W_HOLD : W_FILL;
                end else if (wr_en) begin
                    idx_d = wr_addr + 1'b1;
                end
            end
            W_HOLD: begin
                if (own_free) begin
                    state_d = W_FILL;
                end
            end
            default: state_d = W_FILL;
        endcase
    end

endmodule

// File: rtl/cpx_rd_fsm.sv
module cpx_rd_fsm
    import cpx_pkg::*;
#(
    parameter int SYM_LEN = 64,
    parameter int CP_LEN  = 16,
    localparam int IDX_W  = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_ready,
    input  logic [1:0]       full,
    output logic             out_valid,
    output logic             out_last,
    output logic             rd_sel,
    output logic [IDX_W-1:0] rd_addr,
    output logic [1:0]       clr_vec
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SYM_LEN - 1);
    localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(SYM_LEN - CP_LEN);

    rd_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             sel_q, sel_d;
    logic             take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            idx_q   <= FIRST_IDX;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        out_valid = (state_q != R_IDLE);
        out_last  = (state_q == R_BODY) && (idx_q == LAST_IDX);
        rd_sel    = sel_q;
        rd_addr   = idx_q;
        take      = out_valid && out_ready;
        clr_vec   = 2'b00;
        if (take && out_last) begin
            clr_vec[sel_q] = 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        sel_d   = sel_q;
        unique case (state_q)
            R_IDLE: begin
                if (full[sel_q]) begin
                    state_d = R_PREFIX;
                    idx_d   = FIRST_IDX;
                end
            end
            R_PREFIX: begin
                if (take) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = R_BODY;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            R_BODY: begin
                if (take) begin
                    if (idx_q == LAST_IDX) begin
                        sel_d   = ~sel_q;
                        idx_d   = FIRST_IDX;
                        state_d = full[~sel_q] ? R_PREFIX : R_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = R_IDLE;
        endcase
    end

endmodule

// File: rtl/cpx_extender.sv
module cpx_extender #(
    parameter int DATA_W  = 16,
    parameter int SYM_LEN = 64,
    parameter int CP_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);

    localparam int SMP_W = 2 * DATA_W;
    localparam int IDX_W = $clog2(SYM_LEN);

    logic [1:0]       full;
    logic [1:0]       set_vec;
    logic [1:0]       clr_vec;
    logic             wr_en;
    logic             wr_sel;
    logic [IDX_W-1:0] wr_addr;
    logic             rd_sel;
    logic [IDX_W-1:0] rd_addr;
    logic [SMP_W-1:0] rd_data;

    cpx_wr_fsm #(
        .SYM_LEN (SYM_LEN)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .full     (full),
        .clr_vec  (clr_vec),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_addr  (wr_addr),
        .set_vec  (set_vec)
    );

    cpx_occupancy u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .full    (full)
    );

    cpx_bank #(
        .SMP_W   (SMP_W),
        .SYM_LEN (SYM_LEN)
    ) u_bank (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data ({in_i, in_q}),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cpx_rd_fsm #(
        .SYM_LEN (SYM_LEN),
        .CP_LEN  (CP_LEN)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_ready (out_ready),
        .full      (full),
        .out_valid (out_valid),
        .out_last  (out_last),
        .rd_sel    (rd_sel),
        .rd_addr   (rd_addr),
        .clr_vec   (clr_vec)
    );

    assign out_i = rd_data[SMP_W-1:DATA_W];
    assign out_q = rd_data[DATA_W-1:0];

endmodule

// File: rtl/cpx_extender_chk.sv
module cpx_extender_chk #(
    parameter int DATA_W  = 16,
    parameter int SYM_LEN = 64,
    parameter int CP_LEN  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_first,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [DATA_W-1:0] out_i,
    input logic [DATA_W-1:0] out_q
);

    localparam int TOTAL = SYM_LEN + CP_LEN;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0] in_cnt;
    logic [CNT_W-1:0] out_cnt;
    logic [2:0]       held;
    logic             in_done;
    logic             out_done;

    always_comb begin
        in_done  = in_valid && in_ready && !in_first &&
                   (in_cnt == CNT_W'(SYM_LEN - 1));
        out_done = out_valid && out_ready && out_last;
    end

    // Symbols completed at the input but not yet fully sent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            held    <= '0;
        end else begin
            if (in_valid && in_ready) begin
                if (in_first)     in_cnt <= CNT_W'(1);
                else if (in_done) in_cnt <= '0;
                else              in_cnt <= in_cnt + 1'b1;
            end
            if (out_valid && out_ready) begin
                out_cnt <= out_last ? '0 : out_cnt + 1'b1;
            end
            held <= held + {2'b00, in_done} - {2'b00, out_done};
        end
    end

    // R1: last flag exactly on the 80th sample
    a_r1_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |-> (out_cnt == CNT_W'(TOTAL - 1)));

    a_r1_end_has_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (out_cnt == CNT_W'(TOTAL - 1))) |-> out_last);

    a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5: at most two unsent symbols; output only with stored data
    a_r5_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        held <= 3'd2);

    a_r5_out_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (held != 3'd0));

    // R6: input held off when both buffers are occupied
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (held == 3'd2) |-> !in_ready);

    // R7: stalled output is stable
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_i) &&
                                       $stable(out_q) && $stable(out_last)));

endmodule

bind cpx_extender cpx_extender_chk #(
    .DATA_W  (DATA_W),
    .SYM_LEN (SYM_LEN),
    .CP_LEN  (CP_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_first  (in_first),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/tb_cpx_extender.sv
module tb_cpx_extender;

    localparam int DATA_W  = 16;
    localparam int SYM_LEN = 64;
    localparam int CP_LEN  = 16;
    localparam int TOTAL   = SYM_LEN + CP_LEN;

    // Each entry: upper nibble = symbol tag, lower nibble = sink ready pattern
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h51, 8'h63};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_first = 1'b0;
    logic [DATA_W-1:0] in_i = '0;
    logic [DATA_W-1:0] in_q = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              out_last;
    logic [DATA_W-1:0] out_i;
    logic [DATA_W-1:0] out_q;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    cpx_extender #(
        .DATA_W  (DATA_W),
        .SYM_LEN (SYM_LEN),
        .CP_LEN  (CP_LEN)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_first  (in_first),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample n of the symbol with the given tag: {I, Q}
    function automatic logic [31:0] smp(input int tag, input int n);
        logic [7:0] t;
        logic [7:0] k;
        t = tag[7:0];
        k = n[7:0];
        return {t, k, k ^ 8'h3C, ~t};
    endfunction

    // Input index carried by output position k
    function automatic int src_idx(input int k);
        return (k < CP_LEN) ? (SYM_LEN - CP_LEN + k) : (k - CP_LEN);
    endfunction

    function automatic bit ready_pat(input int mode, input int cyc);
        case (mode)
            0:       return 1'b1;
            1:       return (cyc % 2) == 0;
            2:       return (cyc % 3) != 2;
            default: return ((cyc * 7 + 3) % 5) != 0;
        endcase
    endfunction

    task automatic send_sym(input int tag, input int count, output int waits);
        waits = 0;
        for (int n = 0; n < count; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            {in_i, in_q} = smp(tag, n);
            in_first = (n == 0);
            while (!in_ready) begin
                waits++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic recv_sym(input int tag, input int mode, input bit nogap);
        int          k = 0;
        int          cyc = 0;
        bit          stalled = 1'b0;
        logic [32:0] held_val = '0;
        logic [31:0] exp;
        while (k < TOTAL) begin
            @(negedge clk);
            if (stalled) begin
                // R7: stalled output must not move
                chk(out_valid && ({out_last, out_i, out_q} == held_val), "R7",
                    {out_i, out_q}, held_val[31:0]);
            end
            if (nogap && cyc == 0) begin
                // R10: next symbol valid right after the previous last sample
                chk(out_valid == 1'b1, "R10", {31'd0, out_valid}, 32'd1);
            end
            out_ready = ready_pat(mode, cyc);
            cyc++;
            stalled  = out_valid && !out_ready;
            held_val = {out_last, out_i, out_q};
            if (out_valid && out_ready) begin
                exp = smp(tag, src_idx(k));
                chk({out_i, out_q} == exp, (k < CP_LEN) ? "R2" : "R3",
                    {out_i, out_q}, exp);
                chk(out_last == (k == TOTAL - 1), "R1",
                    {31'd0, out_last}, {31'd0, k == TOTAL - 1});
                k++;
            end
        end
    endtask

    task automatic park();
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int          w;
        logic [31:0] e;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && in_ready, "R11",
            {29'd0, out_valid, out_last, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_last && in_ready, "R11",
            {29'd0, out_valid, out_last, in_ready}, 32'd1);

        // R9 and R4: latency from the 64th input to the first output
        send_sym(8'hA0, SYM_LEN, w);
        chk(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R9", {31'd0, out_valid}, 32'd1);
        e = smp(8'hA0, SYM_LEN - CP_LEN);
        chk(out_i == e[31:16], "R4", {16'd0, out_i}, {16'd0, e[31:16]});
        chk(out_q == e[15:0], "R4", {16'd0, out_q}, {16'd0, e[15:0]});
        recv_sym(8'hA0, 0, 1'b0);
        park();

        // Vector table: varied data and sink ready patterns
        for (int v = 0; v < NVEC; v++) begin
            int tag;
            int mode;
            int wv;
            tag  = {28'd0, VEC[v][7:4]} + 8'hB0;
            mode = {28'd0, VEC[v][3:0]};
            fork
                send_sym(tag, SYM_LEN, wv);
                recv_sym(tag, mode, 1'b0);
            join
            park();
        end

        // R5 and R6: fill both buffers with the sink stalled
        out_ready = 1'b0;
        send_sym(8'hC1, SYM_LEN, w);
        send_sym(8'hC2, SYM_LEN, w);
        chk(w == 0, "R5", w, 32'd0);
        chk(in_ready == 1'b0, "R6", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1;
        {in_i, in_q} = smp(8'hC3, 0);
        in_first = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R6", {31'd0, in_ready}, 32'd0);
        end
        fork
            send_sym(8'hC3, SYM_LEN, w);
            begin
                recv_sym(8'hC1, 0, 1'b0);
                recv_sym(8'hC2, 0, 1'b1);
                recv_sym(8'hC3, 0, 1'b1);
            end
        join
        park();

        // R8: in_first abandons a partial symbol
        send_sym(8'hD1, 20, w);
        send_sym(8'hD2, SYM_LEN, w);
        recv_sym(8'hD2, 2, 1'b0);
        park();
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R8", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule